// File: doc/BRIEF.md
# Converter Streaming Read Master

This block is the host side of a serial link to a delta-sigma converter that signals "conversion ready" by pulling its shared data-out line low. On a start request it drops chip select, writes the mode setup, and then collects conversion words. It can collect them in one of two ways. In command-per-read mode it sends a read command each time ready falls and then clocks in the word. In streaming mode it sends a one-time stream-enter command and afterwards only applies the clocks needed for each word.

Every collected word appears on a 24-bit output, zero-extended, with a one-cycle valid pulse. A stop request ends the session. In streaming mode the exit command may only go out while the ready line is low, so the block holds the stop until that window opens. Other features:
- A wait timeout reports a converter that has gone quiet.
- A separate request sends a run of ones that resets the converter's serial interface.
- The serial clock rate is set by a divider parameter.

Top module: `adc_stream_host`

## Requirements
- R1: Out of reset and whenever no session is active, cs_n is 1, sclk is 1, mosi is 0 and word_valid is 0.
- R2: After start, the first 24 bits sent with cs_n low are the byte 0x08 followed by the 16-bit MODE_WORD (default 0x200A), most significant bit first.
- R3: sclk idles high; mosi changes only when sclk falls, miso is sampled when sclk rises, and each low and each high half lasts CLK_DIV clock cycles.
- R4: In command-per-read mode (stream_en = 0 at start), each time the registered miso is seen low the block sends the byte 0x58 and then applies exactly WORD_BITS clocks to read the word.
- R5: In streaming mode (stream_en = 1 at start), the byte 0x5C is sent once after the setup. After that, each ready gets exactly WORD_BITS clocks with mosi held at 0.
- R6: Each word read is presented on word_data, received MSB first and zero-extended to 24 bits, together with a word_valid pulse lasting exactly one cycle while cs_n is low.
- R7: A stop_req in streaming mode is held until miso is seen low. The block then sends 0x58 instead of reading, raises cs_n and produces no word_valid for that conversion.
- R8: A stop_req in command-per-read mode takes effect while the block waits for ready: cs_n rises with no further command sent.
- R9: If miso is not seen in the expected level within timeout_limit cycles of waiting, timeout_err pulses for one cycle and cs_n rises in the same cycle.
- R10: reset_req while idle sends 32 consecutive ones with cs_n low, then returns to idle.
- R11: After each word the block waits for miso to return high before it accepts the next ready, so one conversion is never read twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a session (pulse while idle) |
| stream_en | input | 1 | Session mode captured at start: 1 streaming, 0 command-per-read |
| stop_req | input | 1 | Request to end the running session (pulse) |
| reset_req | input | 1 | Send the 32-ones interface reset (pulse while idle) |
| timeout_limit | input | TIMEOUT_W | Maximum wait cycles for a level change on miso |
| miso | input | 1 | Converter data-out, doubling as active-low ready |
| sclk | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| word_valid | output | 1 | One-cycle pulse marking a new word |
| word_data | output | 24 | Last word read, zero-extended |
| timeout_err | output | 1 | One-cycle pulse when a wait times out |

## Verification
The assertions assume that start and reset_req arrive only while cs_n is high. They also assume that miso, once pulled low for ready, holds the data bits stable across each rising sclk, and returns high after the final data bit or after the exit command. The bench drives miso from a behavioural converter model that reacts only to sclk edges and to the bytes it decodes. Each conversion is armed only after the previous word has been fully clocked out, so no word is ever overrun. Pulse inputs are applied for a single cycle at falling clock edges, and only in the states where the requirements give them meaning.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
   localparam logic [7:0] CMD_MODE_WR = 8'h08;
   localparam logic [7:0] CMD_READ    = 8'h58;
   localparam logic [7:0] CMD_STREAM  = 8'h5C;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XFER,
      ST_WAIT_HI,
      ST_WAIT_RDY
   } host_state_e;

   typedef enum logic [2:0] {
      K_SETUP,
      K_ENTER,
      K_CMD,
      K_READ,
      K_EXIT,
      K_RST
   } xfer_kind_e;
endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!en || cnt == CW'(DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = en && (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/adc_serial_shift.sv
module adc_serial_shift #(
   parameter int DIV = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic [5:0]  nbits,
   input  logic [31:0] tx,
   input  logic        miso,
   output logic        sclk,
   output logic        mosi,
   output logic        done,
   output logic [31:0] rx
);
   logic        active;
   logic        phase;
   logic [5:0]  left;
   logic [31:0] sreg;
   logic        tick;

   adc_sclk_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (active),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= 1'b0;
         left   <= '0;
         sreg   <= '0;
         sclk   <= 1'b1;
         done   <= 1'b0;
         rx     <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            active <= 1'b1;
            phase  <= 1'b0;
            left   <= nbits;
            sreg   <= tx;
            sclk   <= 1'b0;
            rx     <= '0;
         end else if (active && tick) begin
            if (!phase) begin
               sclk  <= 1'b1;
               rx    <= {rx[30:0], miso};
               phase <= 1'b1;
            end else if (left == 6'd1) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               left  <= left - 1'b1;
               sreg  <= {sreg[30:0], 1'b0};
               sclk  <= 1'b0;
               phase <= 1'b0;
            end
         end
      end
   end

   assign mosi = active & sreg[31];
endmodule

// File: rtl/adc_stream_host.sv
module adc_stream_host
   import adc_host_pkg::*;
#(
   parameter int          CLK_DIV   = 4,
   parameter int          WORD_BITS = 24,
   parameter int          TIMEOUT_W = 20,
   parameter logic [15:0] MODE_WORD = 16'h200A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 stream_en,
   input  logic                 stop_req,
   input  logic                 reset_req,
   input  logic [TIMEOUT_W-1:0] timeout_limit,
   input  logic                 miso,
   output logic                 sclk,
   output logic                 cs_n,
   output logic                 mosi,
   output logic                 word_valid,
   output logic [23:0]          word_data,
   output logic                 timeout_err
);
   localparam int OUT_W = 24;

   generate
      if (WORD_BITS != 16 && WORD_BITS != 24) begin : g_bad_width
         $error("WORD_BITS must be 16 or 24");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (TIMEOUT_W < 2) begin : g_bad_tw
         $error("TIMEOUT_W must be at least 2");
      end
   endgenerate

   host_state_e          state;
   xfer_kind_e           kind;
   logic                 go;
   logic                 stream_q;
   logic                 stop_pend;
   logic                 rdy_q;
   logic [TIMEOUT_W-1:0] tmr;
   logic [5:0]           xfer_bits;
   logic [31:0]          xfer_tx;
   logic                 sh_done;
   logic [31:0]          sh_rx;

   always_comb begin
      xfer_bits = 6'd8;
      xfer_tx   = '0;
      case (kind)
         K_SETUP: begin
            xfer_bits = 6'd24;
            xfer_tx   = {CMD_MODE_WR, MODE_WORD, 8'h00};
         end
         K_ENTER: xfer_tx = {CMD_STREAM, 24'h0};
         K_CMD:   xfer_tx = {CMD_READ, 24'h0};
         K_EXIT:  xfer_tx = {CMD_READ, 24'h0};
         K_READ:  xfer_bits = 6'(WORD_BITS);
         K_RST: begin
            xfer_bits = 6'd32;
            xfer_tx   = '1;
         end
         default: xfer_tx = '0;
      endcase
   end

   adc_serial_shift #(.DIV(CLK_DIV)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .nbits(xfer_bits),
      .tx   (xfer_tx),
      .miso (miso),
      .sclk (sclk),
      .mosi (mosi),
      .done (sh_done),
      .rx   (sh_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         kind        <= K_SETUP;
         go          <= 1'b0;
         stream_q    <= 1'b0;
         stop_pend   <= 1'b0;
         rdy_q       <= 1'b1;
         tmr         <= '0;
         word_valid  <= 1'b0;
         word_data   <= '0;
         timeout_err <= 1'b0;
      end else begin
         rdy_q       <= miso;
         go          <= 1'b0;
         word_valid  <= 1'b0;
         timeout_err <= 1'b0;
         if (stop_req) stop_pend <= 1'b1;
         case (state)
            ST_IDLE: begin
               stop_pend <= 1'b0;
               if (reset_req) begin
                  state <= ST_XFER; kind <= K_RST; go <= 1'b1;
               end else if (start) begin
                  stream_q <= stream_en;
                  state <= ST_XFER; kind <= K_SETUP; go <= 1'b1;
               end
            end
            ST_XFER: begin
               if (sh_done) begin
                  tmr <= '0;
                  case (kind)
                     K_SETUP: begin
                        if (stream_q) begin
                           kind <= K_ENTER; go <= 1'b1;
                        end else begin
                           state <= ST_WAIT_HI;
                        end
                     end
                     K_ENTER: state <= ST_WAIT_HI;
                     K_CMD: begin
                        kind <= K_READ; go <= 1'b1;
                     end
                     K_READ: begin
                        word_valid <= 1'b1;
                        word_data  <= OUT_W'(sh_rx[WORD_BITS-1:0]);
                        state      <= ST_WAIT_HI;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
            ST_WAIT_HI: begin
               if (rdy_q) begin
                  state <= ST_WAIT_RDY;
                  tmr   <= '0;
               end else if (tmr == timeout_limit) begin
                  timeout_err <= 1'b1;
                  state       <= ST_IDLE;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_WAIT_RDY: begin
               if (!stream_q && stop_pend) begin
                  state <= ST_IDLE;
               end else if (!rdy_q) begin
                  state <= ST_XFER;
                  go    <= 1'b1;
                  if (!stream_q)     kind <= K_CMD;
                  else if (stop_pend) kind <= K_EXIT;
                  else               kind <= K_READ;
               end else if (tmr == timeout_limit) begin
                  timeout_err <= 1'b1;
                  state       <= ST_IDLE;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n = (state == ST_IDLE);
endmodule

// File: rtl/adc_stream_host_chk.sv
module adc_stream_host_chk
   import adc_host_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        sclk,
   input logic        mosi,
   input logic        word_valid,
   input logic        timeout_err,
   input logic        go,
   input host_state_e state,
   input xfer_kind_e  kind,
   input logic        rdy_q
);
   p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk && !mosi));

   p_read_din_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER && kind == K_READ) |-> !mosi);

   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   p_valid_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> !cs_n);

   p_exit_on_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && kind == K_EXIT) |-> ($past(rdy_q) == 1'b0));

   p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> cs_n);
endmodule

bind adc_stream_host adc_stream_host_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sclk       (sclk),
   .mosi       (mosi),
   .word_valid (word_valid),
   .timeout_err(timeout_err),
   .go         (go),
   .state      (state),
   .kind       (kind),
   .rdy_q      (rdy_q)
);

// File: tb/tb_adc_stream_host.sv
`timescale 1ns/1ps
module tb_adc_stream_host;
   localparam int DIV = 2;
   localparam int WB  = 16;
   localparam int TW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, stream_en = 1'b0, stop_req = 1'b0, reset_req = 1'b0;
   logic [TW-1:0] timeout_limit = 16'd2000;
   logic          miso_m = 1'b1;
   logic          sclk, cs_n, mosi, word_valid, timeout_err;
   logic [23:0]   word_data;

   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   adc_stream_host #(.CLK_DIV(DIV), .WORD_BITS(WB), .TIMEOUT_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .stream_en(stream_en),
      .stop_req(stop_req), .reset_req(reset_req), .timeout_limit(timeout_limit),
      .miso(miso_m), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .word_valid(word_valid), .word_data(word_data), .timeout_err(timeout_err)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // ---------------- converter model ----------------
   logic [WB-1:0] m_word;
   logic [31:0]   m_sr = '0;
   logic [23:0]   m_setup = '0;
   bit m_rdy = 0, m_data = 0, m_stream = 0, m_setup_done = 0, m_rst_seen = 0, m_exit_ok = 0;
   int m_bits = 0, m_idx = 0, m_last_bits = 0, m_words = 0, m_din_bad = 0, m_exit_cnt = 0;

   always @(negedge sclk) begin
      if (!cs_n && m_data && m_idx < WB) begin
         miso_m = m_word[WB-1-m_idx];
         m_idx++;
      end
   end

   always @(posedge sclk) begin
      if (!cs_n) begin
         m_sr = {m_sr[30:0], mosi};
         m_bits++;
         if (m_bits == 24 && !m_setup_done) begin
            m_setup = m_sr[23:0];
            m_setup_done = 1;
         end
         if (m_bits == 32 && m_sr == 32'hFFFF_FFFF) m_rst_seen = 1;
         if (m_data && m_idx == WB) begin
            if (m_sr[WB-1:0] != '0) m_din_bad++;
            m_words++;
            m_data = 0; m_rdy = 0; miso_m = 1'b1;
         end else if (m_bits % 8 == 0) begin
            if (!m_stream && m_sr[7:0] == 8'h5C) begin
               m_stream = 1;
            end else if (m_stream && m_sr[7:0] == 8'h58) begin
               m_exit_cnt++;
               m_exit_ok = m_rdy;
               m_stream = 0; m_data = 0; m_rdy = 0; miso_m = 1'b1;
            end else if (!m_stream && m_rdy && !m_data && m_sr[7:0] == 8'h58) begin
               m_data = 1; m_idx = 0;
            end
         end
      end
   end

   always @(posedge cs_n) begin
      m_last_bits = m_bits;
      m_bits = 0; m_stream = 0; m_data = 0; m_rdy = 0; miso_m = 1'b1;
   end

   // ---------------- scoreboard ----------------
   logic [WB-1:0] exp_q[$];
   int got = 0, to_cnt = 0;
   int low_run = 0, low_min = 1000, low_max = 0;

   task automatic arm(input logic [WB-1:0] w, input bit expect_word);
      @(negedge clk);
      m_word = w;
      if (expect_word) exp_q.push_back(w);
      m_rdy = 1;
      miso_m = 1'b0;
      if (m_stream) begin
         m_data = 1; m_idx = 0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid) begin
            got++;
            if (exp_q.size() == 0) begin
               check(0, "R6 unexpected word", {8'h0, word_data}, 32'h0);
            end else begin
               logic [WB-1:0] e;
               e = exp_q.pop_front();
               check(word_data == 24'(e), "R6 word value/zero-extension", {8'h0, word_data}, {8'h0, 24'(e)});
            end
         end
         if (timeout_err) to_cnt++;
         if (!cs_n && sclk == 1'b0) low_run++;
         else if (low_run != 0) begin
            if (low_run < low_min) low_min = low_run;
            if (low_run > low_max) low_max = low_run;
            low_run = 0;
         end
      end
   end

   task automatic pulse_start(input bit s);
      @(negedge clk); start = 1'b1; stream_en = s;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && !cs_n; i++) @(negedge clk);
   endtask

   task automatic settle();
      wait (m_rdy == 0);
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all-requirements act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cs_n == 1'b1, "R1 cs_n idle", 32'(cs_n), 32'd1);
      check(sclk == 1'b1, "R1 sclk idle", 32'(sclk), 32'd1);
      check(mosi == 1'b0, "R1 mosi idle", 32'(mosi), 32'd0);
      check(word_valid == 1'b0, "R1 valid idle", 32'(word_valid), 32'd0);

      // command-per-read session
      pulse_start(1'b0);
      wait (m_setup_done);
      repeat (20) @(negedge clk);
      check(m_setup == 24'h08200A, "R2 setup bits", 32'(m_setup), 32'h08200A);
      arm(16'hA5C3, 1); settle();
      arm(16'h0001, 1); settle();
      arm(16'hFFFF, 1); settle();
      check(got == 3, "R4 per-read words", 32'(got), 32'd3);
      pulse_stop();
      wait_idle();
      check(cs_n == 1'b1, "R8 per-read stop releases", 32'(cs_n), 32'd1);
      check(m_last_bits == 24 + 3 * (8 + WB), "R8 R4 bit count", 32'(m_last_bits), 32'(24 + 3 * (8 + WB)));
      check(low_min == DIV && low_max == DIV, "R3 sclk low half", 32'(low_max), 32'(DIV));

      // streaming session
      pulse_start(1'b1);
      wait (m_stream);
      repeat (20) @(negedge clk);
      check(m_stream == 1, "R5 stream enter", 32'(m_stream), 32'd1);
      arm(16'h8000, 1); settle();
      arm(16'h1234, 1); settle();
      arm(16'h7FFE, 1); settle();
      check(got == 6, "R5 stream words", 32'(got), 32'd6);
      check(m_din_bad == 0, "R5 mosi low while streaming", 32'(m_din_bad), 32'd0);
      check(m_words == 6, "R11 each conversion read once", 32'(m_words), 32'd6);

      // stream exit
      pulse_stop();
      repeat (10) @(negedge clk);
      check(cs_n == 1'b0, "R7 stop waits for ready", 32'(cs_n), 32'd0);
      arm(16'hDEAD, 0);
      wait_idle();
      check(cs_n == 1'b1, "R7 exit releases", 32'(cs_n), 32'd1);
      check(m_exit_cnt == 1 && m_exit_ok, "R7 exit while ready low", 32'(m_exit_cnt), 32'd1);
      check(got == 6, "R7 no word on exit", 32'(got), 32'd6);
      check(m_last_bits == 24 + 8 + 3 * WB + 8, "R7 exit bit count", 32'(m_last_bits), 32'(24 + 8 + 3 * WB + 8));

      // timeout
      timeout_limit = 16'd40;
      pulse_start(1'b0);
      for (int i = 0; i < 2000 && to_cnt == 0; i++) @(negedge clk);
      check(to_cnt == 1, "R9 timeout pulse", 32'(to_cnt), 32'd1);
      check(cs_n == 1'b1, "R9 timeout releases", 32'(cs_n), 32'd1);
      timeout_limit = 16'd2000;

      // interface reset
      @(negedge clk); reset_req = 1'b1;
      @(negedge clk); reset_req = 1'b0;
      repeat (3) @(negedge clk);
      wait_idle();
      check(m_rst_seen == 1, "R10 32 ones sent", 32'(m_rst_seen), 32'd1);
      check(m_last_bits == 32, "R10 reset length", 32'(m_last_bits), 32'd32);
      check(exp_q.size() == 0, "R6 all words delivered", 32'(exp_q.size()), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule